// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches up to four power domains on and off in a fixed order that hardware enforces. It drives three 32-bit control words to the rest of the chip. The first is a power-switch word, where a 1 means the domain is unpowered. The second is an active-low reset word, and the third is an active-low isolation word. Each domain has three programmable masks that pick the bits of each word it owns. A domain whose reset mask or isolation mask is zero has no such control, and its sequence leaves that step out.

Software programs the masks and a settle delay through a small register port. It then writes a command that names one domain and a direction. The sequencer applies one step per update, and each update changes only the bits under that domain's mask. Updates are separated by the programmed delay. When the last update is made, the sequencer raises a one-cycle completion pulse. The controller handles one sequence at a time. A command or configuration write that arrives while a sequence runs is dropped.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, `pwr_off` is all ones and `rst_ctl_n` and `iso_ctl_n` are all zeros. `busy`, `done` and every `dom_on` bit are low. The delay and every mask read back as zero.
- R2: A power-up command updates the domain's bits in this order, one update per step. First it clears the power-mask bits in `pwr_off`. Next it sets the reset-mask bits in `rst_ctl_n`. Last it sets the isolation-mask bits in `iso_ctl_n`. The first update is visible one cycle after the command write is accepted.
- R3: A power-down command updates the domain's bits in this order, one update per step. First it clears the isolation-mask bits. Next it clears the reset-mask bits. Last it sets the power-mask bits. The first update is visible one cycle after acceptance.
- R4: A step whose mask is zero is skipped and costs no cycles. The next step that is used takes its place in the schedule.
- R5: Bits outside the masks used by a step keep their value. No cycle ever changes more than one of the three control words.
- R6: Two consecutive updates in a sequence are exactly DELAY+1 cycles apart, where DELAY is the 8-bit settle value (0 to 255).
- R7: `done` is high for exactly one cycle. That cycle is the one in which the final update first shows. `busy` is high from the cycle after acceptance until that cycle, and it is low in that cycle.
- R8: While `busy` is high, command writes, mask writes and delay writes are ignored. While `busy` is low, the three control words do not change in the following cycle.
- R9: `dom_on[d]` is 1 exactly when domain d has a nonzero power mask and all of its power-mask bits in `pwr_off` are 0.
- R10: The register map uses byte addresses. 0x00 is the command register: on write, bits [1:0] give the domain and bit 8 gives the direction (1 = up); on read, bit 0 is busy. 0x04 is the delay, bits [7:0]. 0x08, 0x0C and 0x10 return the power, reset and isolation words. 0x20+4d, 0x40+4d and 0x60+4d hold domain d's power, reset and isolation masks. Reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| pwr_off | output | 32 | Power-switch word, 1 = unpowered |
| rst_ctl_n | output | 32 | Reset word, 0 = held in reset |
| iso_ctl_n | output | 32 | Isolation word, 0 = isolated |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse on the final update |
| dom_on | output | 4 | Per-domain powered status |

## Verification
A wrong step index or a wrong direction flag shows up on the three control words straight away. The affected bits flip in the wrong order, or an update lands in a cycle other than 1+i(DELAY+1) after acceptance. The bench compares all three words with a computed trace in every cycle, so these errors are caught in the first cycle they occur. A settle counter that is loaded wrongly, or that is not locked during a sequence, shifts every later update and moves the `done` pulse. A configuration write that leaks through while busy only shows later, as a different mask read back or as bits of a second domain changing.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    CTL_PWR = 2'd0,
    CTL_RST = 2'd1,
    CTL_ISO = 2'd2
  } ctl_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  localparam int ADDR_W = 8;
  localparam int CMD_DIR_BIT = 8;

  localparam logic [ADDR_W-1:0] A_CMD   = 8'h00;
  localparam logic [ADDR_W-1:0] A_DLY   = 8'h04;
  localparam logic [ADDR_W-1:0] A_PWR   = 8'h08;
  localparam logic [ADDR_W-1:0] A_RST   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_ISO   = 8'h10;
  localparam logic [ADDR_W-1:0] A_PMASK = 8'h20;
  localparam logic [ADDR_W-1:0] A_RMASK = 8'h40;
  localparam logic [ADDR_W-1:0] A_IMASK = 8'h60;
endpackage

// File: rtl/pwrseq_cfg.sv
// Configuration registers, command decode, read mux and per-domain status.
// Mask windows are 32 bytes each, so N_DOM may be at most 8.
module pwrseq_cfg
  import pwrseq_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int N_DOM = 4,
  parameter int DLY_W = 8,
  parameter int DOM_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic [REG_W-1:0]  pwr_q,
  input  logic [REG_W-1:0]  rst_q,
  input  logic [REG_W-1:0]  iso_q,
  input  logic [DOM_W-1:0]  sel_dom,
  output logic              start,
  output logic [DOM_W-1:0]  start_dom,
  output logic              start_up,
  output logic [DLY_W-1:0]  delay,
  output logic [REG_W-1:0]  pm_sel,
  output logic [REG_W-1:0]  rm_sel,
  output logic [REG_W-1:0]  im_sel,
  output logic [N_DOM-1:0]  dom_on
);
  localparam logic [DOM_W:0] N_DOM_L = (DOM_W+1)'(N_DOM);

  logic [REG_W-1:0] pm_q [N_DOM];
  logic [REG_W-1:0] rm_q [N_DOM];
  logic [REG_W-1:0] im_q [N_DOM];
  logic [DLY_W-1:0] dly_q;
  logic             cfg_wr;

  assign cfg_wr    = we && !busy;
  assign start_dom = wdata[DOM_W-1:0];
  assign start_up  = wdata[CMD_DIR_BIT];
  assign start     = cfg_wr && (addr == A_CMD) && ({1'b0, start_dom} < N_DOM_L);
  assign delay     = dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else if (cfg_wr && addr == A_DLY) dly_q <= wdata[DLY_W-1:0];
  end

  AST_DLY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dly_q)); // R8

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    localparam logic [ADDR_W-1:0] PA = A_PMASK + ADDR_W'(4*d);
    localparam logic [ADDR_W-1:0] RA = A_RMASK + ADDR_W'(4*d);
    localparam logic [ADDR_W-1:0] IA = A_IMASK + ADDR_W'(4*d);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pm_q[d] <= '0;
        rm_q[d] <= '0;
        im_q[d] <= '0;
      end else if (cfg_wr) begin
        if (addr == PA) pm_q[d] <= wdata;
        if (addr == RA) rm_q[d] <= wdata;
        if (addr == IA) im_q[d] <= wdata;
      end
    end

    assign dom_on[d] = (pm_q[d] != '0) && ((pwr_q & pm_q[d]) == '0);

    AST_MASK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pm_q[d]) && $stable(rm_q[d]) && $stable(im_q[d]))); // R8
  end

  assign pm_sel = pm_q[sel_dom];
  assign rm_sel = rm_q[sel_dom];
  assign im_sel = im_q[sel_dom];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CMD:   rdata[0] = busy;
      A_DLY:   rdata[DLY_W-1:0] = dly_q;
      A_PWR:   rdata = pwr_q;
      A_RST:   rdata = rst_q;
      A_ISO:   rdata = iso_q;
      default: ;
    endcase
    for (int d = 0; d < N_DOM; d++) begin
      if (addr == A_PMASK + ADDR_W'(4*d)) rdata = pm_q[d];
      if (addr == A_RMASK + ADDR_W'(4*d)) rdata = rm_q[d];
      if (addr == A_IMASK + ADDR_W'(4*d)) rdata = im_q[d];
    end
  end
endmodule

// File: rtl/pwrseq_fsm.sv
// Step sequencer: picks the next used step, applies it, waits the settle delay.
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int DLY_W = 8,
  parameter int DOM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DOM_W-1:0] start_dom,
  input  logic             start_up,
  input  logic [DLY_W-1:0] delay,
  input  logic [REG_W-1:0] pm,
  input  logic [REG_W-1:0] rm,
  input  logic [REG_W-1:0] im,
  output logic [DOM_W-1:0] dom_q,
  output logic             busy,
  output logic             done,
  output logic             apply,
  output ctl_sel_e         sel,
  output logic             set_bits,
  output logic [REG_W-1:0] mask
);
  sq_state_e        state;
  logic [1:0]       step_q;
  logic             up_q;
  logic [DLY_W-1:0] cnt;
  logic [2:0]       used;
  logic [1:0]       cur;
  logic [1:0]       nxt;
  logic             has_nxt;

  // Step slots: up = power, reset, isolation; down = isolation, reset, power.
  always_comb begin
    used[0] = up_q ? 1'b1 : (im != '0);
    used[1] = (rm != '0);
    used[2] = up_q ? (im != '0) : 1'b1;
    cur = 2'd2;
    for (int j = 2; j >= 0; j--) begin
      if (j >= int'(step_q) && used[j]) cur = 2'(j);
    end
    has_nxt = 1'b0;
    nxt     = 2'd2;
    for (int j = 2; j >= 0; j--) begin
      if (j > int'(cur) && used[j]) begin
        has_nxt = 1'b1;
        nxt     = 2'(j);
      end
    end
  end

  always_comb begin
    sel      = CTL_PWR;
    set_bits = 1'b0;
    mask     = pm;
    case (cur)
      2'd0: if (up_q) begin sel = CTL_PWR; set_bits = 1'b0; mask = pm; end
            else      begin sel = CTL_ISO; set_bits = 1'b0; mask = im; end
      2'd1: begin sel = CTL_RST; set_bits = up_q; mask = rm; end
      default: if (up_q) begin sel = CTL_ISO; set_bits = 1'b1; mask = im; end
               else      begin sel = CTL_PWR; set_bits = 1'b1; mask = pm; end
    endcase
  end

  assign apply = (state == SQ_RUN);
  assign busy  = (state != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      step_q <= '0;
      up_q   <= 1'b0;
      dom_q  <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_RUN;
          step_q <= '0;
          up_q   <= start_up;
          dom_q  <= start_dom;
        end
        SQ_RUN: begin
          if (has_nxt) begin
            step_q <= nxt;
            if (delay != '0) begin
              state <= SQ_WAIT;
              cnt   <= delay;
            end
          end else begin
            state <= SQ_IDLE;
            done  <= 1'b1;
          end
        end
        SQ_WAIT: begin
          cnt <= cnt - DLY_W'(1);
          if (cnt == DLY_W'(1)) state <= SQ_RUN;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT) |-> (cnt != '0 && cnt <= delay)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R8
endmodule

// File: rtl/pwrseq_ctl.sv
// The three domain control words, each updated by masked set or clear.
module pwrseq_ctl
  import pwrseq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  ctl_sel_e         sel,
  input  logic             set_bits,
  input  logic [REG_W-1:0] mask,
  input  logic             busy,
  output logic [REG_W-1:0] pwr_q,
  output logic [REG_W-1:0] rst_q,
  output logic [REG_W-1:0] iso_q
);
  function automatic logic [REG_W-1:0] upd(input logic [REG_W-1:0] v,
                                           input logic [REG_W-1:0] m,
                                           input logic s);
    return s ? (v | m) : (v & ~m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= '1;
      rst_q <= '0;
      iso_q <= '0;
    end else if (apply) begin
      case (sel)
        CTL_PWR: pwr_q <= upd(pwr_q, mask, set_bits);
        CTL_RST: rst_q <= upd(rst_q, mask, set_bits);
        CTL_ISO: iso_q <= upd(iso_q, mask, set_bits);
        default: ;
      endcase
    end
  end

  AST_OUTSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> ((((pwr_q ^ $past(pwr_q)) | (rst_q ^ $past(rst_q)) |
                 (iso_q ^ $past(iso_q))) & ~$past(mask)) == '0)); // R5
  AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pwr_q != $past(pwr_q), rst_q != $past(rst_q),
                iso_q != $past(iso_q)}) <= 1); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(pwr_q) && $stable(rst_q) && $stable(iso_q))); // R8
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int N_DOM = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] pwr_off,
  output logic [REG_W-1:0] rst_ctl_n,
  output logic [REG_W-1:0] iso_ctl_n,
  output logic             busy,
  output logic             done,
  output logic [N_DOM-1:0] dom_on
);
  localparam int DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1;

  logic             start, start_up, apply, set_bits;
  logic [DOM_W-1:0] start_dom, dom_q;
  logic [DLY_W-1:0] delay;
  logic [REG_W-1:0] pm_sel, rm_sel, im_sel, mask;
  ctl_sel_e         sel;

  pwrseq_cfg #(.REG_W(REG_W), .N_DOM(N_DOM), .DLY_W(DLY_W), .DOM_W(DOM_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .pwr_q(pwr_off), .rst_q(rst_ctl_n),
    .iso_q(iso_ctl_n), .sel_dom(dom_q), .start(start), .start_dom(start_dom),
    .start_up(start_up), .delay(delay), .pm_sel(pm_sel), .rm_sel(rm_sel),
    .im_sel(im_sel), .dom_on(dom_on)
  );

  pwrseq_fsm #(.REG_W(REG_W), .DLY_W(DLY_W), .DOM_W(DOM_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dom(start_dom),
    .start_up(start_up), .delay(delay), .pm(pm_sel), .rm(rm_sel), .im(im_sel),
    .dom_q(dom_q), .busy(busy), .done(done), .apply(apply), .sel(sel),
    .set_bits(set_bits), .mask(mask)
  );

  pwrseq_ctl #(.REG_W(REG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .apply(apply), .sel(sel), .set_bits(set_bits),
    .mask(mask), .busy(busy), .pwr_q(pwr_off), .rst_q(rst_ctl_n), .iso_q(iso_ctl_n)
  );
endmodule

// File: tb/test_pwrseq_ctrl.sv
module test_pwrseq_ctrl;
  localparam int REG_W = 32;
  localparam int N_DOM = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [7:0]       reg_addr = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata, pwr_off, rst_ctl_n, iso_ctl_n;
  logic             busy, done;
  logic [N_DOM-1:0] dom_on;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pwr = '1, m_rst = '0, m_iso = '0;
  logic [31:0] m_pm [N_DOM];
  logic [31:0] m_rm [N_DOM];
  logic [31:0] m_im [N_DOM];
  int          m_dly = 0;

  pwrseq_ctrl #(.REG_W(REG_W), .N_DOM(N_DOM), .DLY_W(8)) i_pwrseq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_off(pwr_off),
    .rst_ctl_n(rst_ctl_n), .iso_ctl_n(iso_ctl_n), .busy(busy), .done(done),
    .dom_on(dom_on)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_cfg(input int d, input logic [31:0] pm, input logic [31:0] rm,
                         input logic [31:0] im, input int dly);
    wr(8'h20 + 8'(4*d), pm); m_pm[d] = pm;
    wr(8'h40 + 8'(4*d), rm); m_rm[d] = rm;
    wr(8'h60 + 8'(4*d), im); m_im[d] = im;
    wr(8'h04, 32'(dly));     m_dly = dly;
  endtask

  function automatic void step(input int kind, input bit up, input int d,
                               inout logic [31:0] p, inout logic [31:0] r,
                               inout logic [31:0] i);
    case (kind)
      0: p = up ? (p & ~m_pm[d]) : (p | m_pm[d]);
      1: r = up ? (r | m_rm[d]) : (r & ~m_rm[d]);
      default: i = up ? (i | m_im[d]) : (i & ~m_im[d]);
    endcase
  endfunction

  task automatic run_seq(input int d, input bit up, input string req);
    int kinds [3];
    int ek [3];
    int n = 0;
    int klast;
    bit trace_ok = 1'b1, tim_ok = 1'b1;
    logic [31:0] ep, er, ei, bad_a = '0, bad_e = '0;
    if (up) begin
      kinds[n] = 0; n++;
      if (m_rm[d] != 0) begin kinds[n] = 1; n++; end
      if (m_im[d] != 0) begin kinds[n] = 2; n++; end
    end else begin
      if (m_im[d] != 0) begin kinds[n] = 2; n++; end
      if (m_rm[d] != 0) begin kinds[n] = 1; n++; end
      kinds[n] = 0; n++;
    end
    for (int s = 0; s < n; s++) ek[s] = 1 + s * (1 + m_dly);
    klast = ek[n-1];
    wr(8'h00, (up ? 32'h100 : 32'h0) | 32'(d));
    for (int k = 0; k <= klast + 1; k++) begin
      if (k > 0) @(negedge clk);
      ep = m_pwr; er = m_rst; ei = m_iso;
      for (int s = 0; s < n; s++) if (k >= ek[s]) step(kinds[s], up, d, ep, er, ei);
      if (trace_ok && (pwr_off !== ep || rst_ctl_n !== er || iso_ctl_n !== ei)) begin
        trace_ok = 1'b0;
        bad_a = (pwr_off !== ep) ? pwr_off : (rst_ctl_n !== er) ? rst_ctl_n : iso_ctl_n;
        bad_e = (pwr_off !== ep) ? ep : (rst_ctl_n !== er) ? er : ei;
      end
      if (tim_ok && (busy !== (k < klast) || done !== (k == klast))) tim_ok = 1'b0;
    end
    chk(req, "step trace", trace_ok ? bad_e : bad_a, bad_e);
    chk("R7", "done/busy timing", {31'd0, tim_ok}, 32'd1);
    for (int s = 0; s < n; s++) step(kinds[s], up, d, m_pwr, m_rst, m_iso);
    chk("R5", "final words", pwr_off ^ rst_ctl_n ^ iso_ctl_n, m_pwr ^ m_rst ^ m_iso);
    for (int x = 0; x < N_DOM; x++)
      chk("R9", "dom_on", {31'd0, dom_on[x]},
          {31'd0, (m_pm[x] != 0) && ((m_pwr & m_pm[x]) == 0)});
  endtask

  initial begin
    logic [31:0] v;
    string tag;
    int dl [4] = '{0, 1, 2, 5};
    for (int d = 0; d < N_DOM; d++) begin m_pm[d] = '0; m_rm[d] = '0; m_im[d] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "pwr_off", pwr_off, 32'hFFFF_FFFF);
    chk("R1", "rst_ctl_n", rst_ctl_n, 32'h0);
    chk("R1", "iso_ctl_n", iso_ctl_n, 32'h0);
    chk("R1", "busy/done/dom_on", {26'd0, busy, done, dom_on}, 32'h0);
    rd(8'h04, v); chk("R1", "delay", v, 32'h0);
    rd(8'h2C, v); chk("R1", "mask", v, 32'h0);

    // R10 register map read-back
    set_cfg(1, 32'h2, 32'h200, 32'h2_0000, 7);
    rd(8'h24, v); chk("R10", "pmask1", v, 32'h2);
    rd(8'h44, v); chk("R10", "rmask1", v, 32'h200);
    rd(8'h64, v); chk("R10", "imask1", v, 32'h2_0000);
    rd(8'h04, v); chk("R10", "delay", v, 32'd7);
    rd(8'h08, v); chk("R10", "pwr read", v, pwr_off);
    rd(8'h84, v); chk("R10", "unmapped", v, 32'h0);

    // R8 writes while busy are ignored
    set_cfg(0, 32'h1, 32'h100, 32'h1_0000, 20);
    wr(8'h00, 32'h100);
    rd(8'h00, v); chk("R10", "busy bit", v, 32'h1);
    wr(8'h00, 32'h101);
    wr(8'h24, 32'hFF);
    wr(8'h04, 32'd3);
    for (int t = 0; t < 200 && busy; t++) @(negedge clk);
    step(0, 1'b1, 0, m_pwr, m_rst, m_iso);
    step(1, 1'b1, 0, m_pwr, m_rst, m_iso);
    step(2, 1'b1, 0, m_pwr, m_rst, m_iso);
    chk("R8", "pwr after busy cmd", pwr_off, m_pwr);
    chk("R8", "rst after busy cmd", rst_ctl_n, m_rst);
    chk("R8", "iso after busy cmd", iso_ctl_n, m_iso);
    rd(8'h24, v); chk("R8", "mask write dropped", v, 32'h2);
    rd(8'h04, v); chk("R8", "delay write dropped", v, 32'd20);
    repeat (3) @(negedge clk);
    chk("R8", "idle hold", pwr_off, m_pwr);

    // Sweep: every domain, skip pattern, delay, both directions
    for (int d = 0; d < N_DOM; d++)
      for (int c = 0; c < 4; c++)
        for (int di = 0; di < 4; di++) begin
          set_cfg(d, (32'h1 << d) | (32'h10 << d), c[0] ? (32'h100 << d) : 32'h0,
                  c[1] ? (32'h1_0000 << d) : 32'h0, dl[di]);
          for (int u = 1; u >= 0; u--) begin
            if (c != 3) tag = "R4";
            else if (dl[di] != 0) tag = "R6";
            else tag = (u == 1) ? "R2" : "R3";
            run_seq(d, u[0], tag);
          end
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule